// File: doc/BRIEF.md
# Gated 13/16-bit timer-counter

This block is a byte-wide programmable timer-counter for a microcontroller-class subsystem. Its count lives in a low byte and a high byte. In the narrow mode the count is 13 bits wide: the lower five bits of the low byte plus the whole high byte. In the wide mode the two bytes form one 16-bit count. Every increment comes from one of three sources: a falling edge on an external count pin, every cycle of the system clock, or a single-cycle tick from an internal prescaler that divides by 4, 12 or 48.

Counting happens only while a run bit is set. An optional gate can also make counting depend on an external level input whose active polarity is programmable, so the count measures how long that input is active. When the count wraps from its top value to zero, a sticky overflow flag is set. Software loads the count, the control byte and clears the flag through a simple single-cycle write port. A second timer is made by placing a second copy of the block with its own pins.

Top module: `gtc_timer`

## Requirements
- R1: After reset the low byte, the high byte, the control byte and the overflow flag are all zero.
- R2: A write with address 0 loads the low byte, address 1 loads the high byte, address 2 loads the control byte and address 3 clears the overflow flag. The new value is visible from the cycle after the write edge. A write to either count byte takes precedence over an increment in that same cycle.
- R3: With control bit 3 set (wide mode), the two bytes count as one 16-bit value, and the low byte carries into the high byte.
- R4: With control bit 3 clear (narrow mode), only low-byte bits 4:0 and the high byte count as a 13-bit value. A carry out of low bit 4 increments the high byte, and low bits 7:5 keep their value.
- R5: An increment from the all-ones count (13 or 16 bits, depending on the mode) wraps the count to zero and sets the overflow flag. The flag stays set through later counting until a write to address 3 clears it.
- R6: With control bit 2 set, the count advances once for each falling edge of `ext_cnt`, seen after a two-stage synchronizer. Rising edges do not advance it.
- R7: With control bit 2 clear and control bit 5 set, the count advances once every clock cycle while counting is enabled.
- R8: With control bits 2 and 5 clear, the count advances once per prescaler tick. Control bits 7:6 set the tick period: 00 is 4 cycles, 01 is 12 cycles, and 10 or 11 is 48 cycles.
- R9: Control bit 0 (run) must be set for any counting. Setting it does not change the loaded count, and while it is clear the count holds.
- R10: With control bit 1 (gate enable) set, counting also requires the synchronized `ext_gate` level to equal control bit 4 (polarity, 1 = active high). With bit 1 clear, `ext_gate` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Write target: 0 low byte, 1 high byte, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| ext_cnt | input | 1 | External count pin, asynchronous |
| ext_gate | input | 1 | External gate level, asynchronous |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ctrl_o | output | 8 | Current control byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and prescale periods of 4, 12 and 48 cycles. These short periods let a run window of a few dozen cycles hold a whole number of prescaler ticks. The count expected after each window is therefore exact whatever the prescaler phase. Because the count width is fixed at 13 or 16 bits, wraps are reached by preloading the all-ones value and allowing a single increment, instead of counting through the whole range.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    localparam int BYTE_W = 8;
    localparam int M0_LOW = 5;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd3;

    typedef struct packed {
        logic [1:0] scale;
        logic       sys_src;
        logic       gate_pol;
        logic       wide;
        logic       pin_src;
        logic       gate_en;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        ctrl_t             ctrl;
        logic              ovf;
    } tstate_t;

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i <= STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign fall  = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
    parameter int DIV0 = 4,
    parameter int DIV1 = 12,
    parameter int DIV2 = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int W = $clog2(DIV2);

    logic [W-1:0] cnt_d, cnt_q;
    logic         tick_d, tick_q;
    logic [W-1:0] lim;

    always_comb begin
        unique case (sel)
            2'b00:   lim = W'(DIV0 - 1);
            2'b01:   lim = W'(DIV1 - 1);
            default: lim = W'(DIV2 - 1);
        endcase
        if (cnt_q >= lim) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end else begin
            cnt_d  = cnt_q + 1'b1;
            tick_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
    import gtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV0        = 4,
    parameter int DIV1        = 12,
    parameter int DIV2        = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ext_cnt,
    input  logic              ext_gate,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              ovf_flag
);
    localparam int FULL_W = 2 * BYTE_W;

    tstate_t st_d, st_q;

    logic pin_lvl, pin_fall;
    logic gate_lvl, gate_fall_unused;
    logic pre_tick;

    gtc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_cnt),
        .level(pin_lvl), .fall(pin_fall)
    );

    gtc_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_gate),
        .level(gate_lvl), .fall(gate_fall_unused)
    );

    gtc_prescale #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(st_q.ctrl.scale), .tick(pre_tick)
    );

    logic              wr_lo, wr_hi, wr_ctrl, wr_flag;
    logic              gate_ok, enable, src_tick, inc, wrap;
    logic [FULL_W:0]   sum_full;
    logic [M0_LOW:0]   sum_low;
    logic [BYTE_W:0]   sum_hi;

    always_comb begin
        st_d     = st_q;
        wrap     = 1'b0;
        wr_lo    = wr_en && (wr_addr == A_LO);
        wr_hi    = wr_en && (wr_addr == A_HI);
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_flag  = wr_en && (wr_addr == A_FLAG);

        // gate level XOR inverted polarity: active when level matches polarity
        gate_ok  = gate_lvl ^ ~st_q.ctrl.gate_pol;
        enable   = st_q.ctrl.run && (!st_q.ctrl.gate_en || gate_ok);

        if (st_q.ctrl.pin_src)      src_tick = pin_fall;
        else if (st_q.ctrl.sys_src) src_tick = 1'b1;
        else                        src_tick = pre_tick;

        inc      = enable && src_tick && !wr_lo && !wr_hi;

        sum_full = {1'b0, st_q.hi, st_q.lo} + 1'b1;
        sum_low  = {1'b0, st_q.lo[M0_LOW-1:0]} + 1'b1;
        sum_hi   = {1'b0, st_q.hi} + {{BYTE_W{1'b0}}, sum_low[M0_LOW]};

        if (inc) begin
            if (st_q.ctrl.wide) begin
                st_d.lo = sum_full[BYTE_W-1:0];
                st_d.hi = sum_full[FULL_W-1:BYTE_W];
                wrap    = sum_full[FULL_W];
            end else begin
                st_d.lo[M0_LOW-1:0] = sum_low[M0_LOW-1:0];
                st_d.hi             = sum_hi[BYTE_W-1:0];
                wrap                = sum_hi[BYTE_W];
            end
        end

        if (wr_lo)   st_d.lo   = wr_data;
        if (wr_hi)   st_d.hi   = wr_data;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(wr_data);
        if (wr_flag) st_d.ovf  = 1'b0;
        if (wrap)    st_d.ovf  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_lo   = st_q.lo;
    assign cnt_hi   = st_q.hi;
    assign ctrl_o   = st_q.ctrl;
    assign ovf_flag = st_q.ovf;
endmodule

// File: rtl/gtc_timer_chk.sv
module gtc_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi,
    input logic [7:0] ctrl_o,
    input logic       ovf_flag
);
    logic wr_cnt;
    assign wr_cnt = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1);

    // R2: low-byte write lands on the next cycle
    assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (cnt_lo == $past(wr_data)));

    // R9: run clear and no count write -> count holds
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[0] && !wr_cnt) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // R4: narrow mode leaves low bits 7:5 untouched
    assert_m0_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[3] && !(wr_en && wr_addr == 2'd0)) |=> (cnt_lo[7:5] == $past(cnt_lo[7:5])));

    // R5: flag is sticky until a clear write
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_en && wr_addr == 2'd3)) |=> ovf_flag);

    // R5: flag rises only with the count at zero
    assert_flag_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && $stable(ctrl_o[3])) |->
        (cnt_hi == 8'd0 && (ctrl_o[3] ? (cnt_lo == 8'd0) : (cnt_lo[4:0] == 5'd0))));
endmodule

bind gtc_timer gtc_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ctrl_o(ctrl_o), .ovf_flag(ovf_flag)
);

// File: tb/gtc_timer_bench.sv
`timescale 1ns/1ps
module gtc_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ext_cnt = 1'b1;
    logic       ext_gate = 1'b0;
    logic [7:0] cnt_lo, cnt_hi, ctrl_o;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] C_RUN  = 8'h01;
    localparam logic [7:0] C_GATE = 8'h02;
    localparam logic [7:0] C_PIN  = 8'h04;
    localparam logic [7:0] C_WIDE = 8'h08;
    localparam logic [7:0] C_POL  = 8'h10;
    localparam logic [7:0] C_SYS  = 8'h20;

    always #10 clk = ~clk;

    gtc_timer u_gtc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ctrl_o(ctrl_o), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // exactly n counting edges with the given control byte
    task automatic run_for(input logic [7:0] c, input int n);
        wr(2'd2, c | C_RUN);
        repeat (n - 1) @(negedge clk);
        wr(2'd2, c & ~C_RUN);
    endtask

    task automatic t_reset;
        check("R1 lo", 32'(cnt_lo), 32'h0);
        check("R1 hi", 32'(cnt_hi), 32'h0);
        check("R1 ctrl", 32'(ctrl_o), 32'h0);
        check("R1 flag", 32'(ovf_flag), 32'h0);
    endtask

    task automatic t_write_run;
        load(16'h1234);
        check("R2 lo load", 32'(cnt_lo), 32'h34);
        check("R2 hi load", 32'(cnt_hi), 32'h12);
        wr(2'd2, C_SYS | C_WIDE);
        check("R2 ctrl load", 32'(ctrl_o), 32'(C_SYS | C_WIDE));
        idle(20);
        check("R9 hold while stopped", {16'h0, cnt_hi, cnt_lo}, 32'h1234);
        run_for(C_SYS | C_WIDE, 1);
        check("R9 run keeps loaded count", {16'h0, cnt_hi, cnt_lo}, 32'h1235);
        wr(2'd2, C_SYS | C_WIDE | C_RUN);
        idle(5);
        wr(2'd0, 8'h40);
        check("R2 write beats increment", 32'(cnt_lo), 32'h40);
        wr(2'd2, C_SYS | C_WIDE);
    endtask

    task automatic t_wide;
        wr(2'd2, C_SYS | C_WIDE);
        load(16'h00F0);
        run_for(C_SYS | C_WIDE, 48);
        check("R3 R7 wide carry", {16'h0, cnt_hi, cnt_lo}, 32'h0120);
        load(16'hFFFF);
        run_for(C_SYS | C_WIDE, 1);
        check("R5 wide wrap count", {16'h0, cnt_hi, cnt_lo}, 32'h0000);
        check("R5 wide flag set", 32'(ovf_flag), 32'h1);
        wr(2'd3, 8'h00);
        check("R5 flag cleared", 32'(ovf_flag), 32'h0);
    endtask

    task automatic t_narrow;
        wr(2'd2, C_SYS);
        load(16'h053F);
        run_for(C_SYS, 1);
        check("R4 carry from bit4 lo", 32'(cnt_lo), 32'h20);
        check("R4 carry into hi", 32'(cnt_hi), 32'h06);
        check("R4 no flag", 32'(ovf_flag), 32'h0);
        load(16'hFFFF);
        run_for(C_SYS, 1);
        check("R5 R4 narrow wrap lo", 32'(cnt_lo), 32'hE0);
        check("R5 narrow wrap hi", 32'(cnt_hi), 32'h00);
        check("R5 narrow flag set", 32'(ovf_flag), 32'h1);
        run_for(C_SYS, 3);
        check("R5 flag sticky", 32'(ovf_flag), 32'h1);
        check("R4 upper bits held", 32'(cnt_lo), 32'hE3);
        wr(2'd3, 8'hFF);
        check("R5 flag clear write", 32'(ovf_flag), 32'h0);
    endtask

    task automatic t_pin;
        load(16'h0000);
        wr(2'd2, C_PIN | C_WIDE | C_RUN);
        idle(5);
        for (int i = 0; i < 5; i++) begin
            ext_cnt = 1'b0; idle(4);
            ext_cnt = 1'b1; idle(4);
        end
        check("R6 five falling edges", 32'(cnt_lo), 32'h5);
        ext_cnt = 1'b0; idle(4);
        check("R6 falling edge counts", 32'(cnt_lo), 32'h6);
        ext_cnt = 1'b1; idle(4);
        check("R6 rising edge ignored", 32'(cnt_lo), 32'h6);
        wr(2'd2, C_PIN | C_WIDE);
        ext_cnt = 1'b0; idle(4);
        ext_cnt = 1'b1; idle(4);
        check("R9 pin edge while stopped", 32'(cnt_lo), 32'h6);
    endtask

    task automatic t_prescale;
        wr(2'd2, C_WIDE);
        idle(60);
        load(16'h0000);
        run_for(C_WIDE, 48);
        check("R8 divide by 4", {16'h0, cnt_hi, cnt_lo}, 32'd12);
        wr(2'd2, C_WIDE | 8'h40);
        idle(60);
        load(16'h0000);
        run_for(C_WIDE | 8'h40, 48);
        check("R8 divide by 12", {16'h0, cnt_hi, cnt_lo}, 32'd4);
        wr(2'd2, C_WIDE | 8'h80);
        idle(60);
        load(16'h0000);
        run_for(C_WIDE | 8'h80, 96);
        check("R8 divide by 48", {16'h0, cnt_hi, cnt_lo}, 32'd2);
    endtask

    task automatic t_gate;
        ext_gate = 1'b0;
        wr(2'd2, C_GATE | C_POL | C_SYS | C_WIDE);
        idle(10);
        load(16'h0000);
        run_for(C_GATE | C_POL | C_SYS | C_WIDE, 20);
        check("R10 active-high gate low blocks", 32'(cnt_lo), 32'd0);
        ext_gate = 1'b1; idle(10);
        run_for(C_GATE | C_POL | C_SYS | C_WIDE, 20);
        check("R10 active-high gate high counts", 32'(cnt_lo), 32'd20);
        wr(2'd2, C_GATE | C_SYS | C_WIDE);
        run_for(C_GATE | C_SYS | C_WIDE, 20);
        check("R10 active-low gate high blocks", 32'(cnt_lo), 32'd20);
        ext_gate = 1'b0; idle(10);
        run_for(C_GATE | C_SYS | C_WIDE, 10);
        check("R10 active-low gate low counts", 32'(cnt_lo), 32'd30);
        ext_gate = 1'b1; idle(10);
        run_for(C_SYS | C_WIDE, 5);
        check("R10 gate off ignores input", 32'(cnt_lo), 32'd35);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_write_run();
        t_wide();
        t_narrow();
        t_pin();
        t_prescale();
        t_gate();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule